// File: doc/BRIEF.md
# Bit-Serial Unsigned Divider

This block divides an unsigned dividend by an unsigned divisor. It produces a quotient and a remainder such that the dividend equals quotient times divisor plus remainder, with the remainder smaller than the divisor. The dividend and divisor widths are set by separate parameters. The quotient is as wide as the dividend, and the remainder is as wide as the divisor. The block uses radix-2 restoring long division. Each clock cycle it shifts the next dividend bit into a partial remainder. It subtracts the divisor when that subtraction does not go negative, and it records one quotient bit. One division is processed at a time.

Operands enter through a valid/ready handshake. Results leave through a second valid/ready handshake that honours backpressure. The controller has three named states:

- `ST_IDLE`: waiting for operands, with `in_ready` high. The transition *accept* (taken when `in_valid` is high) loads the operands and moves to `ST_RUN`.
- `ST_RUN`: resolves one quotient bit per cycle. The transition *finish* is taken on the last of `DVD_W` iterations and moves to `ST_DONE`.
- `ST_DONE`: presents the result with `out_valid` high. The transition *release* is taken when `out_ready` is high and returns to `ST_IDLE`.

A zero divisor needs no special path. Because every trial subtraction succeeds, the quotient comes out as all ones and the shifted-in dividend bits are left in the remainder.

Top module: `bitserial_divider`

## Requirements
- R1: For a nonzero divisor, the result satisfies `quotient = floor(dividend / divisor)` and `remainder = dividend - quotient*divisor`. Both are computed from the operands captured at acceptance.
- R2: While `out_valid` is high and the captured divisor is nonzero, `remainder` is strictly less than that divisor.
- R3: A zero divisor yields a quotient of all ones (every one of the `DVD_W` bits set) and a remainder equal to the dividend modulo 2^`DSR_W`. It completes with the same latency as any other division.
- R4: Operands are captured on the rising edge where `in_valid` and `in_ready` are both high. Values on `dividend`, `divisor` and `in_valid` at any other time have no effect on a division in progress or on a result being held.
- R5: `in_ready` is high only in `ST_IDLE`. It is low from the edge after acceptance until the output handshake completes, and it is never high together with `out_valid`.
- R6: `out_valid` rises exactly `DVD_W` clock edges after the accepting edge.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `quotient` and `remainder` keep their values on the next cycle.
- R8: After an edge where `out_valid` and `out_ready` are both high, `out_valid` is low and `in_ready` is high on the next cycle.
- R9: While `rst_n` is low, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `dividend`/`divisor` are valid |
| in_ready | output | 1 | Divider is idle and will accept operands |
| dividend | input | DVD_W | Unsigned dividend |
| divisor | input | DSR_W | Unsigned divisor |
| out_valid | output | 1 | Quotient and remainder are valid |
| out_ready | input | 1 | Consumer takes the result |
| quotient | output | DVD_W | Unsigned quotient |
| remainder | output | DSR_W | Unsigned remainder |

## Verification
The bench builds the divider with an 8-bit dividend and a 4-bit divisor, a narrower divisor than dividend. With these widths, every divisor value from zero through fifteen is reachable, including the zero-divisor path. Maximal and minimal dividends and quotients that fill all eight bits are also reachable. An 8-cycle latency keeps runs of several hundred divisions short, while random output backpressure and garbage on the operand inputs during busy periods exercise the hold and capture rules.

// File: rtl/div_pkg.sv
package div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_step.sv
// One radix-2 restoring iteration: shift in a dividend bit, trial subtract.
module div_step #(
    parameter int DSR_W = 8
) (
    input  logic [DSR_W-1:0] rem_in,
    input  logic             next_bit,
    input  logic [DSR_W-1:0] divisor,
    output logic [DSR_W-1:0] rem_out,
    output logic             q_bit
);
    localparam int TW = DSR_W + 1;

    logic [TW-1:0] trial;
    logic [TW-1:0] diff;

    always_comb begin
        trial   = {rem_in, next_bit};
        diff    = trial - {1'b0, divisor};
        q_bit   = (trial >= {1'b0, divisor});
        rem_out = q_bit ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
    end
endmodule

// File: rtl/div_ctrl.sv
// Sequencer: idle / run / done with iteration counter.
module div_ctrl
    import div_pkg::*;
#(
    parameter int DVD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load,
    output logic step
);
    localparam int CW = $clog2(DVD_W + 1);
    localparam logic [CW-1:0] LAST = CW'(DVD_W - 1);

    div_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)      cnt_q <= '0;
            else if (step) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)      state_d = ST_RUN;
            ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
            ST_DONE: if (out_ready)     state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        load      = 1'b0;
        step      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
                load     = in_valid;
            end
            ST_RUN:  step      = 1'b1;
            ST_DONE: out_valid = 1'b1;
            default: ;
        endcase
    end

    // R5
    ready_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);
    // R5
    ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));
    // R7
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid);
    // R8
    release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |=> !out_valid && in_ready);
endmodule

// File: rtl/bitserial_divider.sv
module bitserial_divider #(
    parameter int DVD_W = 16,
    parameter int DSR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DSR_W-1:0] divisor,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DVD_W-1:0] quotient,
    output logic [DSR_W-1:0] remainder
);
    localparam int LW = $clog2(DVD_W + 1) + 1;

    logic             load, step;
    logic [DVD_W-1:0] quot_q;
    logic [DSR_W-1:0] rem_q, dsr_q, rem_nx;
    logic             q_bit;

    div_ctrl #(.DVD_W(DVD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .load      (load),
        .step      (step)
    );

    div_step #(.DSR_W(DSR_W)) u_step (
        .rem_in   (rem_q),
        .next_bit (quot_q[DVD_W-1]),
        .divisor  (dsr_q),
        .rem_out  (rem_nx),
        .q_bit    (q_bit)
    );

    // Dividend bits shift out of the top while quotient bits enter at the bottom.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quot_q <= '0;
            rem_q  <= '0;
            dsr_q  <= '0;
        end else if (load) begin
            quot_q <= dividend;
            rem_q  <= '0;
            dsr_q  <= divisor;
        end else if (step) begin
            quot_q <= {quot_q[DVD_W-2:0], q_bit};
            rem_q  <= rem_nx;
        end
    end

    assign quotient  = quot_q;
    assign remainder = rem_q;

    // Latency observer used only by the checks below.
    logic [LW-1:0] lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       lat_q <= '0;
        else if (in_valid && in_ready)    lat_q <= '0;
        else if (!in_ready && !out_valid) lat_q <= lat_q + 1'b1;
    end

    // R6
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> lat_q == LW'(DVD_W));
    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && dsr_q != '0 |-> remainder < dsr_q);
    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> $stable(quotient) && $stable(remainder));
endmodule

// File: tb/tb_bitserial_divider.sv
`timescale 1ns/1ps
module tb_bitserial_divider;
    localparam int DVD_W = 8;
    localparam int DSR_W = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid, in_ready, out_valid, out_ready;
    logic [DVD_W-1:0] dividend, quotient;
    logic [DSR_W-1:0] divisor, remainder;

    always #2 clk = ~clk;

    bitserial_divider #(.DVD_W(DVD_W), .DSR_W(DSR_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .dividend(dividend), .divisor(divisor),
        .out_valid(out_valid), .out_ready(out_ready),
        .quotient(quotient), .remainder(remainder)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 0;
    int bp_mode = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int               m_st = 0, m_cnt = 0;
    logic [DVD_W-1:0] m_q;
    logic [DSR_W-1:0] m_r, m_dsr;
    bit               m_zero;
    bit               prev_hold = 0;
    logic [DVD_W-1:0] prev_q;
    logic [DSR_W-1:0] prev_r;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            m_st      <= 0;
            prev_hold <= 0;
        end else begin
            prev_hold <= out_valid && !out_ready;
            prev_q    <= quotient;
            prev_r    <= remainder;
            case (m_st)
                0: if (in_valid) begin
                    m_st   <= 1;
                    m_cnt  <= DVD_W;
                    m_dsr  <= divisor;
                    m_zero <= (divisor == 0);
                    if (divisor == 0) begin
                        m_q <= '1;
                        m_r <= DSR_W'(dividend);
                    end else begin
                        m_q <= DVD_W'(dividend / divisor);
                        m_r <= DSR_W'(dividend % divisor);
                    end
                end
                1: begin
                    m_cnt <= m_cnt - 1;
                    if (m_cnt == 1) m_st <= 2;
                end
                2: if (out_ready) m_st <= 0;
                default: m_st <= 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(in_ready == (m_st == 0), "R5 R8 in_ready", in_ready, m_st == 0);
            chk(out_valid == (m_st == 2), "R6 R8 out_valid", out_valid, m_st == 2);
            if (out_valid && m_st == 2) begin
                if (m_zero) begin
                    chk(quotient == m_q, "R3 quotient", quotient, m_q);
                    chk(remainder == m_r, "R3 remainder", remainder, m_r);
                end else begin
                    chk(quotient == m_q, "R1 R4 quotient", quotient, m_q);
                    chk(remainder == m_r, "R1 R4 remainder", remainder, m_r);
                    chk(remainder < m_dsr, "R2 remainder bound", remainder, m_dsr);
                end
            end
            if (prev_hold) begin
                chk(out_valid == 1'b1, "R7 valid held", out_valid, 1);
                chk(quotient == prev_q, "R7 quotient held", quotient, prev_q);
                chk(remainder == prev_r, "R7 remainder held", remainder, prev_r);
            end
        end
    end

    // Output-side backpressure
    always @(negedge clk) begin
        if (bp_mode == 0) out_ready <= 1'b1;
        else              out_ready <= ($urandom_range(0, 1) == 1);
    end

    task automatic send(input logic [DVD_W-1:0] a, input logic [DSR_W-1:0] b);
        @(negedge clk);
        while (!in_ready) begin
            in_valid = ($urandom_range(0, 1) == 1);
            dividend = DVD_W'($urandom);
            divisor  = DSR_W'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b1;
        dividend = a;
        divisor  = b;
        @(negedge clk);
        // R4: garbage on the operand side while busy
        in_valid = ($urandom_range(0, 1) == 1);
        dividend = ~a;
        divisor  = DSR_W'($urandom);
    endtask

    task automatic summary();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        dividend = '0;
        divisor  = '0;
        repeat (3) begin
            @(negedge clk);
            chk(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
            chk(out_valid == 1'b0, "R9 reset out_valid", out_valid, 0);
        end
        rst_n = 1'b1;

        // Directed corners: zero dividend, max dividend, zero divisor, equal operands
        send(8'd0,   4'd1);
        send(8'd255, 4'd1);
        send(8'd255, 4'd15);
        send(8'd7,   4'd9);
        send(8'd200, 4'd0);
        send(8'd0,   4'd0);
        send(8'd255, 4'd0);
        send(8'd100, 4'd7);
        send(8'd15,  4'd15);
        send(8'd128, 4'd3);

        bp_mode = 1;
        for (int i = 0; i < 400; i++) begin
            send(DVD_W'($urandom), DSR_W'($urandom));
        end

        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        summary();
    end
endmodule